// File: doc/BRIEF.md
# Multi-mode DRAM parity checker

This block sits between a shared local bus and a DRAM array that stores one parity bit per byte lane. On writes it produces even parity for every byte lane of the write data, so the array can store those bits alongside the data. On reads it compares the stored parity with the returned data, but only on the lanes the access enables. It ends every access with exactly one single-cycle pulse: either an acknowledge or a bus error.

A two-bit policy register selects how parity is handled. When checking is off, every access finishes at the base latency and never reports an error. In strict mode, every access takes one extra clock and a parity error is reported as a bus error in the failing access. In deferred mode the outcome depends on the master. A processor access still finishes at the base latency, and a processor read parity error does not fail that access. Instead the error is held in a sticky flag, and from then on every processor DRAM access ends in a bus error. Any other master pays one extra clock and gets its error in the access itself.

The sticky flag can be cleared by software, either with a clear strobe or by writing a different policy value. The array is modelled outside the block as a synchronous store whose read data and stored parity are valid while the access is in progress.

Top module: `dram_parity_guard`

## Requirements
- R1: After reset, `ack`, `berr` and `err_pending` are low and the policy register holds code 00 (checking off).
- R2: `mem_wpar[i]` is the even-parity bit of byte lane i of `cyc_wdata` (the XOR of bits 8i..8i+7), for every lane and at all times.
- R3: Policy codes are 00 off, 01 deferred, 10 strict, and 11 behaves as off. The policy in force at the edge that accepts `cyc_start` governs the whole access. With checking off, no access ever ends in `berr`.
- R4: The response pulse appears on the L-th rising edge after the edge that accepts `cyc_start`. L is BASE_LAT for off mode and for processor accesses in deferred mode. L is BASE_LAT+1 in strict mode and for non-processor accesses in deferred mode.
- R5: A read has a parity error when some lane i has `cyc_be[i]` set and its data byte together with `mem_rpar[i]` has odd parity. Disabled lanes are never checked, and writes never raise a parity error.
- R6: In strict mode, a parity error from any master ends that access with `berr` instead of `ack`.
- R7: In deferred mode, a non-processor (`cyc_cpu`=0) read with a parity error ends in `berr` and leaves `err_pending` unchanged.
- R8: In deferred mode, a processor read with a parity error ends in `ack` and sets `err_pending` on the same edge.
- R9: In deferred mode, while `err_pending` is set, every processor access (read or write) ends in `berr`. Non-processor accesses are not affected.
- R10: `err_pending` is cleared by `clr_sticky`, or by a `mode_wr` whose value differs from the current policy. A write of the same policy value leaves it set. If a set and a clear fall on the same edge, the set wins.
- R11: `ack` and `berr` are never high together, each is a one-cycle pulse, and `cyc_start` is ignored while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the policy register |
| mode_wdata | input | 2 | New policy code |
| clr_sticky | input | 1 | Software clear of the pending processor error |
| cyc_start | input | 1 | Start of a DRAM access |
| cyc_cpu | input | 1 | 1 when the owning master is the processor |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| cyc_be | input | DATA_W/8 | Byte-lane enables |
| cyc_wdata | input | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from the array |
| mem_rpar | input | DATA_W/8 | Stored parity bits from the array |
| mem_wpar | output | DATA_W/8 | Parity bits to store with write data |
| ack | output | 1 | Access-complete pulse |
| berr | output | 1 | Bus-error pulse ending the access |
| err_pending | output | 1 | Sticky processor parity error |

## Verification
Two things can land on the same edge: the sticky flag being set by a failing processor read in deferred mode, and a software clear of that flag. The bench provokes this by raising `clr_sticky` in the cycle just before the terminal edge of such a read. The reference model keeps the flag set in that case, and `err_pending` must stay high afterwards. A later processor access must then end in `berr`, and a policy change is expected to clear the flag.

// File: rtl/dram_parity_guard.sv
module dram_parity_guard #(
  parameter int DATA_W   = 32,
  parameter int BASE_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_wr,
  input  logic [1:0]            mode_wdata,
  input  logic                  clr_sticky,
  input  logic                  cyc_start,
  input  logic                  cyc_cpu,
  input  logic                  cyc_write,
  input  logic [DATA_W/8-1:0]   cyc_be,
  input  logic [DATA_W-1:0]     cyc_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic [DATA_W/8-1:0]   mem_rpar,
  output logic [DATA_W/8-1:0]   mem_wpar,
  output logic                  ack,
  output logic                  berr,
  output logic                  err_pending
);
  localparam int LANES   = DATA_W / 8;
  localparam int MAX_LAT = BASE_LAT + 1;
  localparam int CW      = $clog2(MAX_LAT + 1);
  localparam logic [1:0] M_DEFER  = 2'b01;
  localparam logic [1:0] M_STRICT = 2'b10;

  logic [1:0]       mode_q, cap_mode;
  logic             busy, cap_cpu, cap_wr, sticky;
  logic [LANES-1:0] cap_be, lane_bad;
  logic [CW-1:0]    cnt, need;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mem_wpar[i] = ^cyc_wdata[8*i +: 8];
    assign lane_bad[i] = cap_be[i] & (^{mem_rdata[8*i +: 8], mem_rpar[i]});
  end

  wire checking  = (cap_mode == M_DEFER) || (cap_mode == M_STRICT);
  wire defer_cpu = (cap_mode == M_DEFER) && cap_cpu;
  assign need    = ((cap_mode == M_STRICT) || ((cap_mode == M_DEFER) && !cap_cpu))
                   ? CW'(MAX_LAT) : CW'(BASE_LAT);
  wire fin       = busy && (cnt == need);
  wire perr      = checking && !cap_wr && (|lane_bad);
  wire fail      = (perr && !defer_cpu) || (defer_cpu && sticky);
  wire set_now   = fin && perr && defer_cpu;
  wire clr_now   = clr_sticky || (mode_wr && (mode_wdata != mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      cap_mode <= 2'b00;
      cap_cpu  <= 1'b0;
      cap_wr   <= 1'b0;
      cap_be   <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
      ack      <= 1'b0;
      berr     <= 1'b0;
      sticky   <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_wdata;
      if (!busy && cyc_start) begin
        cap_mode <= mode_q;
        cap_cpu  <= cyc_cpu;
        cap_wr   <= cyc_write;
        cap_be   <= cyc_be;
        busy     <= 1'b1;
        cnt      <= CW'(1);
      end else if (fin) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
      ack  <= fin && !fail;
      berr <= fin && fail;
      if (set_now)      sticky <= 1'b1;
      else if (clr_now) sticky <= 1'b0;
    end
  end

  assign err_pending = sticky;

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && berr));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || berr) |=> !(ack || berr));
  a_r8_sticky_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pending) |-> $past(busy && cap_cpu && !cap_wr && cap_mode == M_DEFER));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky && !(busy && cap_cpu && cap_mode == M_DEFER)) |=> !err_pending);
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !checking) |=> !berr);
endmodule

// File: tb/dram_parity_guard_bench.sv
`timescale 1ns/1ps
module dram_parity_guard_bench;
  localparam int DW = 32;
  localparam int LN = DW / 8;
  localparam int BL = 2;

  logic clk = 0, rst_n = 0;
  logic mode_wr = 0, clr_sticky = 0, cyc_start = 0, cyc_cpu = 0, cyc_write = 0;
  logic [1:0] mode_wdata = 0;
  logic [LN-1:0] cyc_be = 0, mem_rpar = 0, mem_wpar;
  logic [DW-1:0] cyc_wdata = 0, mem_rdata = 0;
  logic ack, berr, err_pending;

  int checks = 0, errors = 0;
  int model_mode = 0;
  bit model_sticky = 0;
  bit done = 0;

  dram_parity_guard #(.DATA_W(DW), .BASE_LAT(BL)) u_dram_parity_guard (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .clr_sticky(clr_sticky), .cyc_start(cyc_start), .cyc_cpu(cyc_cpu),
    .cyc_write(cyc_write), .cyc_be(cyc_be), .cyc_wdata(cyc_wdata),
    .mem_rdata(mem_rdata), .mem_rpar(mem_rpar), .mem_wpar(mem_wpar),
    .ack(ack), .berr(berr), .err_pending(err_pending));

  always #5 clk = ~clk;

  function automatic logic [LN-1:0] even_par(input logic [DW-1:0] d);
    logic [LN-1:0] p;
    for (int l = 0; l < LN; l++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += d[8*l+b];
      p[l] = ones % 2;
    end
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int v);
    mode_wr = 1; mode_wdata = 2'(v);
    @(negedge clk);
    mode_wr = 0;
    if (v != model_mode) model_sticky = 0;
    model_mode = v;
    check("R10 err_pending after policy write", err_pending, model_sticky);
  endtask

  task automatic soft_clear();
    clr_sticky = 1;
    @(negedge clk);
    clr_sticky = 0;
    model_sticky = 0;
    check("R10 err_pending after clear", err_pending, 0);
  endtask

  task automatic run(input string tag, input bit cpu, input bit wr, input logic [LN-1:0] be,
                     input logic [DW-1:0] data, input logic [LN-1:0] corrupt,
                     input bit clr_end, input bit hold);
    int need;
    bit defcpu, perr, eb, chk;
    chk    = (model_mode == 1) || (model_mode == 2);
    defcpu = (model_mode == 1) && cpu;
    need   = (model_mode == 2 || (model_mode == 1 && !cpu)) ? BL + 1 : BL;
    perr   = chk && !wr && ((be & corrupt) != 0);
    eb     = (perr && !defcpu) || (defcpu && model_sticky);
    cyc_start = 1; cyc_cpu = cpu; cyc_write = wr; cyc_be = be;
    cyc_wdata = data; mem_rdata = data; mem_rpar = even_par(data) ^ corrupt;
    #1;
    check({"R2 write parity ", tag}, mem_wpar, even_par(data));
    for (int i = 1; i <= need + 1; i++) begin
      @(negedge clk);
      if (!hold || i == need + 1) cyc_start = 0;
      clr_sticky = 0;
      if (i == need + 1) begin
        if (defcpu && perr) model_sticky = 1;
        else if (clr_end) model_sticky = 0;
      end
      check({"R4 ack ", tag}, ack, (i == need + 1) && !eb);
      check({"R4 berr ", tag}, berr, (i == need + 1) && eb);
      check({"R9 err_pending ", tag}, err_pending, model_sticky);
      if (clr_end && i == need) clr_sticky = 1;
    end
    @(negedge clk);
    check({"R11 pulse ends ", tag}, ack | berr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack reset", ack, 0);
    check("R1 berr reset", berr, 0);
    check("R1 err_pending reset", err_pending, 0);
    rst_n = 1;
    @(negedge clk);

    run("R3 off cpu corrupt", 1, 0, 4'hF, 32'h1234_5678, 4'h1, 0, 0);
    run("R3 off dma corrupt", 0, 0, 4'hF, 32'hDEAD_BEEF, 4'hA, 0, 0);
    run("R11 start held busy", 1, 0, 4'hF, 32'h0F0F_00FF, 4'h0, 0, 1);
    run("R2 write a", 1, 1, 4'hF, 32'hA5C3_0181, 4'h0, 0, 0);

    set_mode(3);
    run("R3 code11 as off", 0, 0, 4'hF, 32'h7777_0001, 4'hF, 0, 0);

    set_mode(2);
    run("R6 strict cpu clean", 1, 0, 4'hF, 32'hCAFE_F00D, 4'h0, 0, 0);
    run("R6 strict cpu corrupt", 1, 0, 4'hF, 32'hCAFE_F00D, 4'h4, 0, 0);
    run("R6 strict dma corrupt", 0, 0, 4'h3, 32'h0000_0101, 4'h2, 0, 0);
    run("R5 disabled lane", 1, 0, 4'h3, 32'h8000_0001, 4'h8, 0, 0);
    run("R5 write no error", 0, 1, 4'hF, 32'h1111_2222, 4'hF, 0, 0);

    set_mode(1);
    run("R4 defer cpu clean", 1, 0, 4'hF, 32'h0102_0304, 4'h0, 0, 0);
    run("R4 defer dma clean", 0, 0, 4'hF, 32'h0102_0304, 4'h0, 0, 0);
    run("R7 defer dma corrupt", 0, 0, 4'hF, 32'hF0F0_F0F0, 4'h1, 0, 0);
    run("R8 defer cpu corrupt", 1, 0, 4'hF, 32'hF0F0_F0F0, 4'h1, 0, 0);
    run("R9 cpu write sticky", 1, 1, 4'hF, 32'h5555_AAAA, 4'h0, 0, 0);
    run("R9 cpu read sticky", 1, 0, 4'hF, 32'h5555_AAAA, 4'h0, 0, 0);
    run("R9 dma unaffected", 0, 0, 4'hF, 32'h5555_AAAA, 4'h0, 0, 0);
    soft_clear();
    run("R10 cpu after clear", 1, 0, 4'hF, 32'h2468_ACE0, 4'h0, 0, 0);

    run("R10 set wins over clear", 1, 0, 4'hF, 32'h1357_9BDF, 4'h2, 1, 0);
    run("R10 still sticky", 1, 0, 4'hF, 32'h1357_9BDF, 4'h0, 0, 0);
    set_mode(1);
    check("R10 same policy keeps flag", err_pending, 1);
    set_mode(2);
    set_mode(1);
    run("R10 cpu after policy change", 1, 0, 4'hF, 32'h0000_0000, 4'h0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule